// File: doc/BRIEF.md
# Packed Byte and Word Media Unit

This block is a 64-bit SIMD-style datapath for small integer media kernels. A function code selects one operation. Eight operations pick, lane by lane, the smaller or the larger of two packed operands, with eight 8-bit lanes or four 16-bit lanes, compared as signed or unsigned values. The other operations are:

- a sum of absolute byte differences across all lanes;
- byte gather and scatter between word or longword lanes;
- a population count;
- sign extension of a byte or a halfword.

The function is fully combinational. The result is captured in one output register, so a result appears on the clock edge after its operands and code are presented. A new operation can be issued on every cycle. The output register clears under a synchronous active-high reset.

Top module: `media_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes zero. Otherwise `result` takes, at each rising edge, the function of the `op_a`, `op_b` and `func` values present at that edge.
- R2: Byte-lane min and max work on 8-bit lane i = bits [8i+7:8i]. Each result lane is the selected lane of A or of B, kept in the same lane position. The codes are: 0x38 signed min, 0x3A unsigned min, 0x3C unsigned max, 0x3E signed max.
- R3: Word-lane min and max work the same way on 16-bit lane i = bits [16i+15:16i]. The codes are: 0x39 signed min, 0x3B unsigned min, 0x3D unsigned max, 0x3F signed max.
- R4: Signed forms treat the top bit of a lane as its sign and unsigned forms do not. For example, byte 0x80 is the signed minimum of 0x80 and 0x01 but the unsigned maximum.
- R5: Code 0x31 returns the sum of |A byte i − B byte i| over all eight unsigned byte lanes, zero-extended to 64 bits.
- R6: Code 0x34 places B bytes 0..3 at result bit offsets 0, 16, 32 and 48. Code 0x35 places B bytes 0 and 1 at offsets 0 and 32. All other result bits are zero.
- R7: Code 0x36 moves the low byte of each 16-bit lane of B into result bytes 0..3. Code 0x37 moves B[7:0] and B[39:32] into result bytes 0 and 1. All other result bits are zero.
- R8: Code 0x30 returns the number of set bits in B.
- R9: Code 0x00 returns B[7:0] sign-extended to 64 bits. Code 0x01 returns B[15:0] sign-extended to 64 bits. Operand A has no effect on either.
- R10: Any function code not named above returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| func | input | 8 | Function code |
| result | output | 64 | Registered result |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath and an 8-bit function code. The wide code covers every value above 0x3F as well as the gaps between the defined codes, so the zero result for unused codes can be checked on both sides of the defined range. The 64-bit width gives eight byte lanes and four word lanes. This is enough to place opposite-sign lanes side by side, to compare positive lanes against negative ones, and to fill every lane with the same value for full-range population and difference sums.

// File: rtl/media_pkg.sv
package media_pkg;
  localparam int FUNC_W = 8;

  localparam logic [FUNC_W-1:0] F_SXT_B   = 8'h00;
  localparam logic [FUNC_W-1:0] F_SXT_W   = 8'h01;
  localparam logic [FUNC_W-1:0] F_POPC    = 8'h30;
  localparam logic [FUNC_W-1:0] F_SAD     = 8'h31;
  localparam logic [FUNC_W-1:0] F_UNPK_BW = 8'h34;
  localparam logic [FUNC_W-1:0] F_UNPK_BL = 8'h35;
  localparam logic [FUNC_W-1:0] F_PACK_WB = 8'h36;
  localparam logic [FUNC_W-1:0] F_PACK_LB = 8'h37;

  // min/max block spans 0x38..0x3F:
  // bit0 = word lanes, bit2 = max, signed when bit2 == bit1
  localparam logic [FUNC_W-4:0] F_MM_BASE = 5'b00111;

  function automatic logic is_minmax(input logic [FUNC_W-1:0] f);
    return f[FUNC_W-1:3] == F_MM_BASE;
  endfunction

  function automatic logic is_known(input logic [FUNC_W-1:0] f);
    return is_minmax(f) || f == F_SXT_B || f == F_SXT_W || f == F_POPC ||
           f == F_SAD || f == F_UNPK_BW || f == F_UNPK_BL ||
           f == F_PACK_WB || f == F_PACK_LB;
  endfunction
endpackage

// File: rtl/lane_minmax.sv
module lane_minmax #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  input  logic              is_max,
  output logic [DATA_W-1:0] y
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LANE_W-1:0] la, lb, pick;
    logic a_lt, a_gt, a_wins;
    assign la = a[i*LANE_W +: LANE_W];
    assign lb = b[i*LANE_W +: LANE_W];
    always_comb begin
      if (is_signed) begin
        a_lt = $signed(la) < $signed(lb);
        a_gt = $signed(la) > $signed(lb);
      end else begin
        a_lt = la < lb;
        a_gt = la > lb;
      end
      a_wins = is_max ? a_gt : a_lt;
      pick   = a_wins ? la : lb;
    end
    assign y[i*LANE_W +: LANE_W] = pick;

    always_comb begin
      AST_LANE_SOURCE: assert (pick == la || pick == lb); // R2
    end
  end
endmodule

// File: rtl/sad_unit.sv
module sad_unit #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum
);
  localparam int NB    = DATA_W / 8;
  localparam int SUM_W = 9 + $clog2(NB);

  logic [SUM_W-1:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < NB; i++) begin
      if (a[i*8 +: 8] >= b[i*8 +: 8])
        acc = acc + SUM_W'(a[i*8 +: 8] - b[i*8 +: 8]);
      else
        acc = acc + SUM_W'(b[i*8 +: 8] - a[i*8 +: 8]);
    end
    sum = DATA_W'(acc);
  end
endmodule

// File: rtl/shuffle_unit.sv
module shuffle_unit #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] unpk_bw,
  output logic [DATA_W-1:0] unpk_bl,
  output logic [DATA_W-1:0] pack_wb,
  output logic [DATA_W-1:0] pack_lb,
  output logic [DATA_W-1:0] popc,
  output logic [DATA_W-1:0] sxt_b,
  output logic [DATA_W-1:0] sxt_w
);
  localparam int NW    = DATA_W / 16;
  localparam int NL    = DATA_W / 32;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    unpk_bw = '0;
    unpk_bl = '0;
    pack_wb = '0;
    pack_lb = '0;
    for (int i = 0; i < NW; i++) begin
      unpk_bw[i*16 +: 8] = b[i*8 +: 8];
      pack_wb[i*8 +: 8]  = b[i*16 +: 8];
    end
    for (int i = 0; i < NL; i++) begin
      unpk_bl[i*32 +: 8] = b[i*8 +: 8];
      pack_lb[i*8 +: 8]  = b[i*32 +: 8];
    end
    cnt = '0;
    for (int i = 0; i < DATA_W; i++) cnt = cnt + CNT_W'(b[i]);
    popc  = DATA_W'(cnt);
    sxt_b = {{(DATA_W-8){b[7]}}, b[7:0]};
    sxt_w = {{(DATA_W-16){b[15]}}, b[15:0]};
  end
endmodule

// File: rtl/media_unit.sv
module media_unit
  import media_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [FUNC_W-1:0] func,
  output logic [DATA_W-1:0] result
);
  localparam int NB = DATA_W / 8;

  logic mm_signed, mm_max;
  assign mm_signed = (func[2] == func[1]);
  assign mm_max    = func[2];

  logic [DATA_W-1:0] mm_byte, mm_word, sad;
  logic [DATA_W-1:0] unpk_bw, unpk_bl, pack_wb, pack_lb, popc, sxt_b, sxt_w;

  lane_minmax #(.DATA_W(DATA_W), .LANE_W(8)) u_mm8 (
    .a(op_a), .b(op_b), .is_signed(mm_signed), .is_max(mm_max), .y(mm_byte));

  lane_minmax #(.DATA_W(DATA_W), .LANE_W(16)) u_mm16 (
    .a(op_a), .b(op_b), .is_signed(mm_signed), .is_max(mm_max), .y(mm_word));

  sad_unit #(.DATA_W(DATA_W)) u_sad (.a(op_a), .b(op_b), .sum(sad));

  shuffle_unit #(.DATA_W(DATA_W)) u_shuf (
    .b(op_b), .unpk_bw(unpk_bw), .unpk_bl(unpk_bl), .pack_wb(pack_wb),
    .pack_lb(pack_lb), .popc(popc), .sxt_b(sxt_b), .sxt_w(sxt_w));

  logic [DATA_W-1:0] nxt;
  always_comb begin
    if (is_minmax(func)) nxt = func[0] ? mm_word : mm_byte;
    else begin
      case (func)
        F_SXT_B:   nxt = sxt_b;
        F_SXT_W:   nxt = sxt_w;
        F_POPC:    nxt = popc;
        F_SAD:     nxt = sad;
        F_UNPK_BW: nxt = unpk_bw;
        F_UNPK_BL: nxt = unpk_bl;
        F_PACK_WB: nxt = pack_wb;
        F_PACK_LB: nxt = pack_lb;
        default:   nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= nxt;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> result == '0); // R1
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !is_known(func) |=> result == '0); // R10
  AST_POPC_RANGE: assert property (@(posedge clk) disable iff (rst)
    func == F_POPC |=> result <= DATA_W); // R8
  AST_SAD_RANGE: assert property (@(posedge clk) disable iff (rst)
    func == F_SAD |=> result <= NB * 255); // R5
  AST_SXT_UPPER: assert property (@(posedge clk) disable iff (rst)
    func == F_SXT_B |=> (result[DATA_W-1:7] == '0 || result[DATA_W-1:7] == '1)); // R9
  AST_UNPK_HOLES: assert property (@(posedge clk) disable iff (rst)
    func == F_UNPK_BL |=> $countones(result) == $countones($past(op_b[15:0]))); // R6
endmodule

// File: tb/test_media_unit.sv
module test_media_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0, op_b = '0;
  logic [7:0]  func = '0;
  logic [63:0] result;

  int n_checks = 0;
  int n_fails  = 0;

  media_unit i_media_unit (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
                           .func(func), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] model(input logic [7:0] f, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    if (f >= 8'h38 && f <= 8'h3F) begin
      int w;
      logic sg, mx;
      w  = f[0] ? 16 : 8;
      mx = (f == 8'h3C || f == 8'h3D || f == 8'h3E || f == 8'h3F);
      sg = (f == 8'h38 || f == 8'h39 || f == 8'h3E || f == 8'h3F);
      for (int i = 0; i < 64 / w; i++) begin
        logic [15:0] x, y;
        logic [16:0] xs, ys;
        logic take_a;
        x = (w == 8) ? {8'h00, a[i*8 +: 8]} : a[i*16 +: 16];
        y = (w == 8) ? {8'h00, b[i*8 +: 8]} : b[i*16 +: 16];
        // flip sign bit to map signed order onto unsigned order
        xs = {1'b0, x};
        ys = {1'b0, y};
        if (sg) begin
          xs[w-1] = ~xs[w-1];
          ys[w-1] = ~ys[w-1];
        end
        take_a = mx ? (xs > ys) : (xs < ys);
        if (w == 8) r[i*8 +: 8] = take_a ? x[7:0] : y[7:0];
        else        r[i*16 +: 16] = take_a ? x : y;
      end
    end else begin
      case (f)
        8'h00: r = {{56{b[7]}}, b[7:0]};
        8'h01: r = {{48{b[15]}}, b[15:0]};
        8'h30: for (int i = 0; i < 64; i++) r = r + 64'(b[i]);
        8'h31: for (int i = 0; i < 8; i++) begin
                 int d;
                 d = int'(a[i*8 +: 8]) - int'(b[i*8 +: 8]);
                 r = r + 64'(d < 0 ? -d : d);
               end
        8'h34: r = {8'h00, b[31:24], 8'h00, b[23:16], 8'h00, b[15:8], 8'h00, b[7:0]};
        8'h35: r = {24'h0, b[15:8], 24'h0, b[7:0]};
        8'h36: r = {32'h0, b[55:48], b[39:32], b[23:16], b[7:0]};
        8'h37: r = {48'h0, b[39:32], b[7:0]};
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive on falling edge, register at rising edge, sample at next falling edge
  task automatic run_op(input string tag, input logic [7:0] f, input logic [63:0] a,
                        input logic [63:0] b);
    op_a = a; op_b = b; func = f;
    @(posedge clk);
    @(negedge clk);
    check(tag, result, model(f, a, b));
  endtask

  task automatic t_reset();
    @(negedge clk);
    op_a = '1; op_b = '1; func = 8'h30;
    @(posedge clk); @(negedge clk);
    check("R1 reset holds zero", result, 64'h0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 first result after reset", result, 64'd64);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 reset clears result", result, 64'h0);
    rst = 1'b0;
  endtask

  task automatic t_byte_minmax();
    logic [63:0] a, b;
    a = 64'h7F80_0102_FE10_55AA;
    b = 64'h8001_0201_FF0F_AA55;
    run_op("R2 byte smin", 8'h38, a, b);
    run_op("R2 byte umin", 8'h3A, a, b);
    run_op("R2 byte umax", 8'h3C, a, b);
    run_op("R2 byte smax", 8'h3E, a, b);
    run_op("R2 byte umin swapped", 8'h3A, b, a);
  endtask

  task automatic t_word_minmax();
    logic [63:0] a, b;
    a = 64'h8000_7FFF_1234_FFFF;
    b = 64'h7FFF_8000_1235_0001;
    run_op("R3 word smin", 8'h39, a, b);
    run_op("R3 word umin", 8'h3B, a, b);
    run_op("R3 word umax", 8'h3D, a, b);
    run_op("R3 word smax", 8'h3F, a, b);
  endtask

  task automatic t_sign_order();
    op_a = 64'h80; op_b = 64'h01; func = 8'h38;
    @(posedge clk); @(negedge clk);
    check("R4 signed min picks 0x80", result, 64'h80);
    func = 8'h3C;
    @(posedge clk); @(negedge clk);
    check("R4 unsigned max picks 0x80", result, 64'h80);
    func = 8'h3E;
    @(posedge clk); @(negedge clk);
    check("R4 signed max picks 0x01", result, 64'h01);
  endtask

  task automatic t_sad();
    run_op("R5 sad mixed", 8'h31, 64'h0010_FF00_0305_0A00, 64'h0100_00FF_0503_000A);
    op_a = '1; op_b = '0; func = 8'h31;
    @(posedge clk); @(negedge clk);
    check("R5 sad full range", result, 64'd2040);
  endtask

  task automatic t_unpack();
    run_op("R6 unpack byte-word", 8'h34, 64'hAAAA_AAAA, 64'hFFFF_FFFF_4433_2211);
    op_b = 64'hFFFF_FFFF_FFFF_BBCC; func = 8'h35;
    @(posedge clk); @(negedge clk);
    check("R6 unpack byte-long", result, 64'h0000_00BB_0000_00CC);
  endtask

  task automatic t_pack();
    run_op("R7 pack word-byte", 8'h36, '1, 64'h8877_6655_4433_2211);
    op_b = 64'hFFFF_FF5A_FFFF_FFA5; func = 8'h37;
    @(posedge clk); @(negedge clk);
    check("R7 pack long-byte", result, 64'h5AA5);
  endtask

  task automatic t_popc();
    run_op("R8 popcount zero", 8'h30, '1, 64'h0);
    run_op("R8 popcount pattern", 8'h30, '0, 64'hF0F0_0001_8000_0003);
  endtask

  task automatic t_sext();
    op_a = 64'h1234; op_b = 64'h0000_0000_0000_0080; func = 8'h00;
    @(posedge clk); @(negedge clk);
    check("R9 sext byte negative", result, 64'hFFFF_FFFF_FFFF_FF80);
    op_a = '1; op_b = 64'hFFFF_FFFF_FFFF_7F7F; func = 8'h00;
    @(posedge clk); @(negedge clk);
    check("R9 sext byte positive, A ignored", result, 64'h7F);
    op_b = 64'h0000_0000_0000_8001; func = 8'h01;
    @(posedge clk); @(negedge clk);
    check("R9 sext word negative", result, 64'hFFFF_FFFF_FFFF_8001);
  endtask

  task automatic t_unused();
    logic [7:0] codes [6] = '{8'h02, 8'h2F, 8'h32, 8'h33, 8'h40, 8'hB8};
    foreach (codes[i]) begin
      op_a = '1; op_b = '1; func = codes[i];
      @(posedge clk); @(negedge clk);
      check($sformatf("R10 unused code %h", codes[i]), result, 64'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_byte_minmax();
    t_word_minmax();
    t_sign_order();
    t_sad();
    t_unpack();
    t_pack();
    t_popc();
    t_sext();
    t_unused();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule